// File: doc/BRIEF.md
# Timer Counter with Delayed Overflow Reload

This block holds an 8-bit up-counter and its 8-bit modulo (reload) register. An upstream divider supplies increment pulses. The bus writes either register through separate strobes. When the counter wraps from its all-ones value, the reload from the modulo register and the interrupt request do not happen at once. The counter first reads zero for one whole machine cycle. Only in the following machine cycle does it take the modulo value, and at the start of that cycle a one-clock interrupt pulse is raised.

Time is framed in machine cycles of four input clocks. The machine-cycle strobe is high on the first clock of each machine cycle. Increment pulses are acted on only on strobe clocks. Bus writes may land on any clock. A small state machine tracks three states:

- Counting: normal operation.
- Wrapped: the zero cycle after wrap-around.
- Reloading: the cycle in which the modulo value is forced in.

Its transitions are:

- Counting to Wrapped: an increment at all-ones.
- Wrapped to Reloading: the next strobe, which performs the reload and raises the interrupt.
- Wrapped to Counting: a counter write before that strobe, which cancels both the reload and the interrupt.
- Reloading to Counting: the next strobe, or Reloading to Wrapped if that strobe's increment wraps the counter again.

The modulo register output is transparent: a write shows on its output in the same clock. Any modulo write during the reload cycle is copied into the counter.

Top module: `tmr_reload_top`

## Requirements
- R1: An increment pulse changes the counter only on a clock where the machine-cycle strobe is high; an increment pulse without the strobe has no effect.
- R2: A strobed increment at FFh sets the counter to 00h, and it stays 00h through the following clocks until the next strobe (the Wrapped cycle).
- R3: On the strobe that ends the Wrapped cycle, the counter takes the modulo value and the interrupt output is high for exactly the one clock after that edge.
- R4: A counter write on a non-strobe clock of the Wrapped cycle stores the written value and cancels both the reload and the interrupt.
- R5: A modulo write during the Wrapped cycle does not cancel the reload or the interrupt, and the reload uses the newly written value.
- R6: A counter write on the strobe that opens the reload cycle, or on any later clock of that cycle, is discarded, and the counter keeps the modulo value.
- R7: A modulo write on the strobe that opens the reload cycle, or on any later clock of that cycle, loads the written value into the counter on that same edge and does not change the interrupt output.
- R8: The modulo output equals the write data on the same clock as a modulo write, before the edge.
- R9: A strobed increment below FFh adds one to the counter and raises no interrupt.
- R10: Outside the Wrapped and reload cycles, a counter write wins over a strobed increment on the same clock.
- R11: A strobed increment that coincides with the strobe ending the Wrapped cycle does not suppress the reload; the counter takes the modulo value and the interrupt fires.
- R12: Reset clears the counter and the modulo register, returns the state machine to Counting, and holds the interrupt low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mcyc_stb | input | 1 | High on the first clock of each machine cycle |
| inc_pulse | input | 1 | Increment request from the divider, sampled with mcyc_stb |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Counter write data |
| mod_wr | input | 1 | Modulo register write strobe |
| mod_wdata | input | 8 | Modulo register write data |
| cnt_q | output | 8 | Counter value |
| mod_q | output | 8 | Modulo value, transparent to a same-clock write |
| irq_pulse | output | 1 | One-clock interrupt request at the start of the reload cycle |

## Verification
The hardest situations to reach are bus writes that fall inside the Wrapped or reload cycle on a chosen clock. This matters most at the strobe that separates the two cycles, where a counter write flips from cancelling the reload to being discarded. The bench drives the machine-cycle strobe itself, clock by clock, rather than from a free-running divider. Each scenario therefore first loads FFh and the modulo value, then forces the wrap with one strobed increment. It then places the write, the modulo write or a coinciding increment on an exact clock relative to the strobe.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        ST_COUNT  = 2'd0,
        ST_WRAP   = 2'd1,
        ST_RELOAD = 2'd2
    } tmr_state_e;

    typedef enum logic [1:0] {
        SEL_HOLD = 2'd0,
        SEL_WR   = 2'd1,
        SEL_INC  = 2'd2,
        SEL_MOD  = 2'd3
    } cnt_sel_e;

endpackage

// File: rtl/tmr_mod_latch.sv
module tmr_mod_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mod_wr,
    input  logic [W-1:0] mod_wdata,
    output logic [W-1:0] mod_eff
);

    logic [W-1:0] mod_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mod_r <= '0;
        end else if (mod_wr) begin
            mod_r <= mod_wdata;
        end
    end

    // Transparent view: a write is visible before it is stored.
    always_comb begin
        mod_eff = mod_wr ? mod_wdata : mod_r;
    end

endmodule

// File: rtl/tmr_cnt_path.sv
module tmr_cnt_path
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  cnt_sel_e     sel,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] mod_eff,
    output logic [W-1:0] cnt,
    output logic         at_max
);

    logic [W-1:0] cnt_nxt;

    always_comb begin
        cnt_nxt = cnt;
        unique case (sel)
            SEL_HOLD: cnt_nxt = cnt;
            SEL_WR:   cnt_nxt = wdata;
            SEL_INC:  cnt_nxt = cnt + W'(1);
            SEL_MOD:  cnt_nxt = mod_eff;
            default:  cnt_nxt = cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            cnt <= cnt_nxt;
        end
    end

    always_comb begin
        at_max = &cnt;
    end

endmodule

// File: rtl/tmr_seq_fsm.sv
module tmr_seq_fsm
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stb,
    input  logic       inc,
    input  logic       cnt_wr,
    input  logic       mod_wr,
    input  logic       at_max,
    output tmr_state_e state,
    output cnt_sel_e   sel,
    output logic       irq
);

    tmr_state_e state_nxt;
    logic       irq_set;
    logic       cnt_rules_wr;
    logic       cnt_rules_inc;

    // Ordinary counting rules, shared by Counting and the reload cycle's exit.
    always_comb begin
        cnt_rules_wr  = cnt_wr;
        cnt_rules_inc = !cnt_wr && stb && inc;
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_COUNT: begin
                if (cnt_rules_inc && at_max) state_nxt = ST_WRAP;
            end
            ST_WRAP: begin
                if (stb)         state_nxt = ST_RELOAD;
                else if (cnt_wr) state_nxt = ST_COUNT;
            end
            ST_RELOAD: begin
                if (stb) begin
                    if (cnt_rules_inc && at_max) state_nxt = ST_WRAP;
                    else                         state_nxt = ST_COUNT;
                end
            end
            default: state_nxt = ST_COUNT;
        endcase
    end

    // Output logic: counter source select and interrupt request
    always_comb begin
        sel     = SEL_HOLD;
        irq_set = 1'b0;
        unique case (state)
            ST_COUNT: begin
                if (cnt_rules_wr)       sel = SEL_WR;
                else if (cnt_rules_inc) sel = SEL_INC;
            end
            ST_WRAP: begin
                if (stb) begin
                    sel     = SEL_MOD;
                    irq_set = 1'b1;
                end else if (cnt_wr) begin
                    sel = SEL_WR;
                end
            end
            ST_RELOAD: begin
                if (stb) begin
                    if (cnt_rules_wr)       sel = SEL_WR;
                    else if (cnt_rules_inc) sel = SEL_INC;
                end else if (mod_wr) begin
                    sel = SEL_MOD;
                end
            end
            default: sel = SEL_HOLD;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_COUNT;
            irq   <= 1'b0;
        end else begin
            state <= state_nxt;
            irq   <= irq_set;
        end
    end

    AST_IRQ_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R3

    AST_IRQ_IN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (state == ST_RELOAD)); // R3

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |-> (state == ST_COUNT && !irq)); // R12

endmodule

// File: rtl/tmr_reload_top.sv
module tmr_reload_top
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mcyc_stb,
    input  logic         inc_pulse,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_wdata,
    input  logic         mod_wr,
    input  logic [W-1:0] mod_wdata,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] mod_q,
    output logic         irq_pulse
);

    localparam logic [W-1:0] CNT_MAX = '1;

    tmr_state_e   state;
    cnt_sel_e     sel;
    logic         at_max;
    logic [W-1:0] mod_eff;
    logic [W-1:0] cnt;
    logic         irq;

    tmr_mod_latch #(.W(W)) u_mod (
        .clk       (clk),
        .rst_n     (rst_n),
        .mod_wr    (mod_wr),
        .mod_wdata (mod_wdata),
        .mod_eff   (mod_eff)
    );

    tmr_cnt_path #(.W(W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .wdata   (cnt_wdata),
        .mod_eff (mod_eff),
        .cnt     (cnt),
        .at_max  (at_max)
    );

    tmr_seq_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb    (mcyc_stb),
        .inc    (inc_pulse),
        .cnt_wr (cnt_wr),
        .mod_wr (mod_wr),
        .at_max (at_max),
        .state  (state),
        .sel    (sel),
        .irq    (irq)
    );

    always_comb begin
        cnt_q     = cnt;
        mod_q     = mod_eff;
        irq_pulse = irq;
    end

    AST_WRAP_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRAP) |-> (cnt_q == '0)); // R2

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && mcyc_stb && inc_pulse && !cnt_wr && cnt_q != CNT_MAX)
        |=> (cnt_q == $past(cnt_q) + W'(1) && !irq_pulse)); // R9

    AST_CANCEL_IN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRAP && !mcyc_stb && cnt_wr)
        |=> (cnt_q == $past(cnt_wdata) && state == ST_COUNT)); // R4

    AST_RELOAD_DROPS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RELOAD && !mcyc_stb && cnt_wr && !mod_wr)
        |=> $stable(cnt_q)); // R6

    AST_RELOAD_NEW_MOD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRAP && mcyc_stb && mod_wr)
        |=> (cnt_q == $past(mod_wdata) && irq_pulse)); // R7

    AST_INC_NEEDS_STB: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && !mcyc_stb && !cnt_wr) |=> $stable(cnt_q)); // R1

endmodule

// File: tb/sim_tmr_reload_top.sv
module sim_tmr_reload_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mcyc_stb = 1'b0;
    logic       inc_pulse = 1'b0;
    logic       cnt_wr = 1'b0;
    logic [7:0] cnt_wdata = 8'h00;
    logic       mod_wr = 1'b0;
    logic [7:0] mod_wdata = 8'h00;
    logic [7:0] cnt_q;
    logic [7:0] mod_q;
    logic       irq_pulse;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    tmr_reload_top #(.W(8)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .mcyc_stb  (mcyc_stb),
        .inc_pulse (inc_pulse),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .mod_wr    (mod_wr),
        .mod_wdata (mod_wdata),
        .cnt_q     (cnt_q),
        .mod_q     (mod_q),
        .irq_pulse (irq_pulse)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one clock worth of inputs (called at a falling edge), then sample after the edge.
    task automatic step(input logic s, input logic i, input logic cw, input logic [7:0] cd,
                        input logic mw, input logic [7:0] md);
        mcyc_stb = s; inc_pulse = i; cnt_wr = cw; cnt_wdata = cd; mod_wr = mw; mod_wdata = md;
        @(posedge clk);
        #2;
        mcyc_stb = 1'b0; inc_pulse = 1'b0; cnt_wr = 1'b0; mod_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
    endtask

    // One full machine cycle with no activity, returning the block to Counting.
    task automatic settle();
        step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
        idle(); idle(); idle();
    endtask

    // Load modulo and FFh, then wrap with a strobed increment (Wrapped cycle begins).
    task automatic arm_wrap(input logic [7:0] m);
        settle();
        step(1'b0, 1'b0, 1'b1, 8'hFF, 1'b1, m);
        idle(); idle();
        step(1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00);
    endtask

    task automatic t_reset();
        chk("R12 cnt", cnt_q, 8'h00);
        chk("R12 mod", mod_q, 8'h00);
        chk("R12 irq", {7'd0, irq_pulse}, 8'h00);
    endtask

    task automatic t_plain();
        settle();
        step(1'b0, 1'b0, 1'b1, 8'h45, 1'b0, 8'h00);
        idle(); idle();
        step(1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00);
        chk("R9 inc", cnt_q, 8'h46);
        chk("R9 irq", {7'd0, irq_pulse}, 8'h00);
        step(1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00);
        chk("R1 unstrobed inc", cnt_q, 8'h46);
        idle(); idle();
        step(1'b1, 1'b1, 1'b1, 8'h20, 1'b0, 8'h00);
        chk("R10 write wins", cnt_q, 8'h20);
    endtask

    task automatic t_overflow();
        arm_wrap(8'h23);
        chk("R2 zero", cnt_q, 8'h00);
        idle(); chk("R2 hold", cnt_q, 8'h00);
        idle(); idle();
        chk("R2 hold end", cnt_q, 8'h00);
        chk("R3 no early irq", {7'd0, irq_pulse}, 8'h00);
        step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
        chk("R3 reload", cnt_q, 8'h23);
        chk("R3 irq", {7'd0, irq_pulse}, 8'h01);
        idle();
        chk("R3 irq one clock", {7'd0, irq_pulse}, 8'h00);
    endtask

    task automatic t_cancel();
        arm_wrap(8'h23);
        step(1'b0, 1'b0, 1'b1, 8'h77, 1'b0, 8'h00);
        chk("R4 written", cnt_q, 8'h77);
        idle(); idle();
        step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
        chk("R4 no reload", cnt_q, 8'h77);
        chk("R4 no irq", {7'd0, irq_pulse}, 8'h00);
    endtask

    task automatic t_mod_in_wrap();
        arm_wrap(8'h23);
        step(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 8'h30);
        chk("R5 still zero", cnt_q, 8'h00);
        idle(); idle();
        step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
        chk("R5 reload new", cnt_q, 8'h30);
        chk("R5 irq", {7'd0, irq_pulse}, 8'h01);
    endtask

    task automatic t_write_in_reload();
        arm_wrap(8'h23);
        idle(); idle(); idle();
        step(1'b1, 1'b0, 1'b1, 8'h99, 1'b0, 8'h00);
        chk("R6 strobe write dropped", cnt_q, 8'h23);
        chk("R6 irq", {7'd0, irq_pulse}, 8'h01);
        step(1'b0, 1'b0, 1'b1, 8'h55, 1'b0, 8'h00);
        chk("R6 late write dropped", cnt_q, 8'h23);
    endtask

    task automatic t_mod_in_reload();
        arm_wrap(8'h23);
        idle(); idle(); idle();
        step(1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 8'h5A);
        chk("R7 same edge", cnt_q, 8'h5A);
        chk("R7 irq", {7'd0, irq_pulse}, 8'h01);
        step(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 8'h66);
        chk("R7 late mod", cnt_q, 8'h66);
        chk("R7 irq untouched", {7'd0, irq_pulse}, 8'h00);
    endtask

    task automatic t_transparent();
        settle();
        mod_wr = 1'b1; mod_wdata = 8'hC3;
        #1;
        chk("R8 transparent", mod_q, 8'hC3);
        @(posedge clk); #2; mod_wr = 1'b0;
        chk("R8 stored", mod_q, 8'hC3);
        @(negedge clk);
    endtask

    task automatic t_inc_at_reload();
        arm_wrap(8'h41);
        idle(); idle(); idle();
        step(1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00);
        chk("R11 reload wins", cnt_q, 8'h41);
        chk("R11 irq", {7'd0, irq_pulse}, 8'h01);
    endtask

    initial begin
        #(8 * 20000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_plain();
        t_overflow();
        t_cancel();
        t_mod_in_wrap();
        t_write_in_reload();
        t_mod_in_reload();
        t_transparent();
        t_inc_at_reload();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule